// File: doc/BRIEF.md
# Framed Serial Display Shifter

This block drives a serial display module from a parallel byte source. A host places eight data bits and an externally computed parity bit on the data inputs and, with the record-enable input held low, raises the load strobe. On the strobe's rising edge the block latches the byte and parity and wraps them in a frame. The frame is an eleven-bit word with a low start bit in front and a high stop bit at the end. It then shifts the frame out least significant data bit first on a data pin, next to a free-running serial clock pin.

The serial clock is the system clock divided by 16, which gives 1.25 MHz from a 20 MHz system clock. The data pin changes only when that clock falls, so a receiver samples it on the rising edge. A second divider produces the system clock divided by 4 for an external microcontroller, so that the host runs synchronously with the shifter. A busy output is high while a frame is in flight, and load requests that arrive during that time are dropped.

Top module: `disp_shifter_top`

## Requirements
- R1: After reset, busy is 0, the serial data pin is 1 (idle), and both clock outputs are 0.
- R2: The serial clock output has a period of 16 system clocks and is high for 8 of them.
- R3: The microcontroller clock output has a period of 4 system clocks and is high for 2 of them.
- R4: A rising edge on the load strobe while record-enable is 0 and busy is 0 latches the 8 data bits and the parity bit. Busy is 1 one system clock after the edge is presented.
- R5: The frame on the data pin, sampled at successive serial clock rising edges, is a start bit 0, then data bits 0 to 7 in that order, then the parity bit, then a stop bit 1.
- R6: The serial data pin changes only on system clock edges where the serial clock falls.
- R7: Busy stays 1 through the stop bit and returns to 0 within 20 system clocks of the stop bit's sampling edge. The data pin is 1 whenever busy is 0.
- R8: A load strobe rising edge while busy is 1 is ignored: the current frame is unchanged and no further frame follows.
- R9: A load strobe rising edge while record-enable is 1 is ignored: busy stays 0 and the data pin stays 1.
- R10: A strobe that stays high starts only one frame. Only a new low-to-high transition requests another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_en | input | 1 | Record-enable; shifter loading is selected while it is 0 |
| ld_strobe | input | 1 | Load strobe; its rising edge requests a frame |
| data_in | input | 8 | Parallel data byte |
| parity_in | input | 1 | Externally supplied parity bit |
| mcu_clk | output | 1 | System clock divided by 4 |
| ser_clk | output | 1 | System clock divided by 16 |
| ser_data | output | 1 | Serial frame data, idles high |
| busy | output | 1 | High while a frame is being shifted |

## Verification
The frame path is driven with all-zero and all-one bytes of both parity values, an alternating pattern, and a run of random bytes and parities. The all-zero and all-one bytes show whether the start and stop bits sit in the right places around the data. The alternating and random bytes expose bit-order and off-by-one shifting faults. Strobes are also issued mid-frame with a different byte on the bus, with record-enable high, and held high across the end of a frame. These separate a correctly ignored request from one that corrupts or restarts the frame. The two clock outputs are timed edge to edge to tell their dividers apart.

// File: rtl/disp_shifter_pkg.sv
package disp_shifter_pkg;

  // Build the outgoing frame, bit 0 leaves first:
  // [0] start (0), [DW:1] data LSB first, [DW+1] parity, [DW+2] stop (1)
  function automatic logic [31:0] build_frame(input logic [15:0] data,
                                              input logic parity,
                                              input int dw);
    logic [31:0] f;
    f = '0;
    f[0] = 1'b0;
    for (int i = 0; i < dw; i++) f[i+1] = data[i];
    f[dw+1] = parity;
    f[dw+2] = 1'b1;
    return f;
  endfunction

  function automatic int frame_len(input int dw);
    return dw + 3;
  endfunction

endpackage

// File: rtl/disp_clk_div.sv
module disp_clk_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_out,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign fall_evt = (cnt == CW'(HALF - 1));
  assign rise_evt = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else begin
      if (rise_evt) begin
        cnt     <= '0;
        clk_out <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (fall_evt) clk_out <= 1'b0;
      end
    end
  end

  // R2
  period_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(rise_evt));
  // R3
  period_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> $past(fall_evt));

endmodule

// File: rtl/disp_load_ctrl.sv
module disp_load_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_en,
  input  logic ld_strobe,
  input  logic busy,
  output logic load_req,
  output logic load_acc
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= ld_strobe;
  end

  assign load_req = ld_strobe & ~strobe_q & ~rec_en;
  assign load_acc = load_req & ~busy;

  // R8
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_acc);

endmodule

// File: rtl/disp_frame_shift.sv
module disp_frame_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_acc,
  input  logic [DATA_W-1:0] data_in,
  input  logic              parity_in,
  input  logic              fall_evt,
  output logic              ser_data,
  output logic              busy
);
  import disp_shifter_pkg::*;

  localparam int FW = frame_len(DATA_W);
  localparam int SW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [SW-1:0] sent;
  logic [31:0]   frame_w;
  logic          last_done;

  assign frame_w   = build_frame(16'(data_in), parity_in, DATA_W);
  assign last_done = (sent == SW'(FW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '1;
      sent     <= '0;
      busy     <= 1'b0;
      ser_data <= 1'b1;
    end else if (load_acc) begin
      sh   <= frame_w[FW-1:0];
      sent <= '0;
      busy <= 1'b1;
    end else if (busy && fall_evt) begin
      if (last_done) begin
        busy     <= 1'b0;
        ser_data <= 1'b1;
      end else begin
        ser_data <= sh[0];
        sh       <= {1'b1, sh[FW-1:1]};
        sent     <= sent + 1'b1;
      end
    end
  end

  // R6
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> $past(fall_evt));
  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_data);
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_acc));
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_evt)) |-> $stable(sh));
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sent <= SW'(FW)));

endmodule

// File: rtl/disp_shifter_top.sv
module disp_shifter_top #(
  parameter int DATA_W   = 8,
  parameter int SCLK_DIV = 16,
  parameter int MCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en,
  input  logic              ld_strobe,
  input  logic [DATA_W-1:0] data_in,
  input  logic              parity_in,
  output logic              mcu_clk,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              busy
);
  logic sclk_fall, sclk_rise, mclk_fall, mclk_rise;
  logic load_req, load_acc;

  disp_clk_div #(.DIV(SCLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .clk_out(ser_clk),
    .fall_evt(sclk_fall), .rise_evt(sclk_rise));

  disp_clk_div #(.DIV(MCLK_DIV)) u_mclk (
    .clk(clk), .rst_n(rst_n), .clk_out(mcu_clk),
    .fall_evt(mclk_fall), .rise_evt(mclk_rise));

  disp_load_ctrl u_ld (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .ld_strobe(ld_strobe),
    .busy(busy), .load_req(load_req), .load_acc(load_acc));

  disp_frame_shift #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load_acc(load_acc), .data_in(data_in),
    .parity_in(parity_in), .fall_evt(sclk_fall),
    .ser_data(ser_data), .busy(busy));

  // R9
  rec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |-> !load_acc);
  // R4
  req_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |-> load_req);

endmodule

// File: tb/tb_disp_shifter_top.sv
`timescale 1ns/1ps
module tb_disp_shifter_top;
  logic clk = 0, rst_n = 0, rec_en = 1, ld_strobe = 0, parity_in = 0;
  logic [7:0] data_in = 0;
  logic mcu_clk, ser_clk, ser_data, busy;
  int checks = 0, fails = 0;

  disp_shifter_top dut (.clk(clk), .rst_n(rst_n), .rec_en(rec_en),
    .ld_strobe(ld_strobe), .data_in(data_in), .parity_in(parity_in),
    .mcu_clk(mcu_clk), .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected bit k of the frame, restated from R5
  function automatic logic exp_bit(input int k, input logic [7:0] d, input logic p);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return p;
    return 1'b1;
  endfunction

  task automatic quiet(input string req, input int n);
    logic ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy !== 1'b0 || ser_data !== 1'b1) ok = 0;
    end
    chk(req, ok, 1);
  endtask

  // mode 0 plain, 1 mid-frame strobe with other data, 2 strobe held high
  task automatic send(input logic [7:0] d, input logic p, input int mode);
    logic got;
    int k;
    @(negedge clk);
    data_in = d; parity_in = p; rec_en = 0; ld_strobe = 1;
    @(negedge clk);
    chk("R4 busy", busy, 1);
    if (mode != 2) ld_strobe = 0;
    k = 0;
    for (int t = 0; t < 3; t++) begin
      @(posedge ser_clk); @(negedge clk);
      if (ser_data === 1'b0) break;
    end
    chk("R5 start", ser_data, 0);
    if (mode == 1) begin
      data_in = ~d; parity_in = ~p; ld_strobe = 1;
      @(negedge clk); ld_strobe = 0;
    end
    for (int b = 1; b <= 10; b++) begin
      @(posedge ser_clk); @(negedge clk);
      got = ser_data;
      chk((b == 10) ? "R5 stop" : "R5 bit", got, exp_bit(b, d, p));
      if (b == 10) chk("R7 busy thru stop", busy, 1);
    end
    k = 0;
    while (busy === 1'b1 && k < 20) begin @(negedge clk); k++; end
    chk("R7 busy clears", busy, 0);
    chk("R7 idle", ser_data, 1);
    if (mode == 1) quiet("R8 no extra frame", 48);
    if (mode == 2) begin quiet("R10 held strobe", 48); ld_strobe = 0; end
  endtask

  task automatic run_all();
    realtime t1, t2, t3;
    logic [31:0] r;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 data", ser_data, 1);
    chk("R1 sclk", ser_clk, 0);
    chk("R1 mclk", mcu_clk, 0);
    rst_n = 1;
    @(posedge ser_clk); t1 = $realtime;
    @(negedge ser_clk); t2 = $realtime;
    @(posedge ser_clk); t3 = $realtime;
    chk("R2 high", int'((t2 - t1) / 20.0), 8);
    chk("R2 period", int'((t3 - t1) / 20.0), 16);
    @(posedge mcu_clk); t1 = $realtime;
    @(negedge mcu_clk); t2 = $realtime;
    @(posedge mcu_clk); t3 = $realtime;
    chk("R3 high", int'((t2 - t1) / 20.0), 2);
    chk("R3 period", int'((t3 - t1) / 20.0), 4);
    // R9: strobe with record-enable high
    @(negedge clk); rec_en = 1; data_in = 8'h3C; ld_strobe = 1;
    @(negedge clk); ld_strobe = 0;
    quiet("R9 ignored", 40);
    send(8'h00, 1'b0, 0);
    send(8'hFF, 1'b1, 0);
    send(8'hA5, 1'b1, 1);
    send(8'h5A, 1'b0, 2);
    for (int i = 0; i < 20; i++) begin
      r = $urandom;
      send(r[7:0], r[8], (r[9] ? 1 : 0));
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule